// File: doc/BRIEF.md
# Controller Serial Input Receiver

This block gathers game-controller input lines through an external parallel-in, serial-out shift register. It starts each frame by raising a load strobe. The external converter then captures its parallel inputs. Next the block generates a serial clock and takes one data bit on every rising edge of that clock. One frame carries sixteen bits. The first eight are the quadrature signals of two mouse ports. The last eight are miscellaneous control bits.

When the last bit of a frame has been taken, all outputs update together on a single clock edge:

- The quadrature bits are presented to the downstream counter logic as a horizontal pair and a vertical pair for each port.
- The control bits are presented as a status byte.

The next frame's load strobe follows straight away, so the block samples continuously with no gaps. The rate of the serial clock is set by a divider parameter.

Top module: `ctrl_serial_rx`

## Requirements
- R1: While reset is high, and on the first clock edge that follows it, `loadOut`, `sclkOut`, `frameDone`, `horizPair`, `vertPair` and `statusByte` are all zero.
- R2: `loadOut` rises on the first clock edge after reset is released. It stays high for exactly one serial-clock period, which is 2*DIV_HALF clock cycles. `loadOut` and `sclkOut` are never high in the same cycle.
- R3: After the load strobe, `sclkOut` runs for exactly 16 periods. In each period it is low for DIV_HALF cycles and then high for DIV_HALF cycles.
- R4: `serIn` is sampled on the clock edge at which `sclkOut` goes from 0 to 1. The first bit sampled is stream bit 0.
- R5: Port p receives four stream bits. `horizPair[2p]` is stream bit 4p and `horizPair[2p+1]` is its quadrature partner, stream bit 4p+1. `vertPair[2p]` is stream bit 4p+2 and `vertPair[2p+1]` is stream bit 4p+3.
- R6: `statusByte` holds stream bits 8 to 15, with stream bit 8 in bit 0 and stream bit 15 in bit 7.
- R7: All outputs change only on the edge that samples the sixteenth bit. `frameDone` is high for exactly the one cycle that follows that edge. Between those edges every output keeps its previous value.
- R8: The next load strobe begins on the first edge after the last high phase of the serial clock, so frames repeat every 2*DIV_HALF*17 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial data from the external converter |
| loadOut | output | 1 | Parallel-load strobe to the external converter |
| sclkOut | output | 1 | Serial shift clock to the external converter |
| horizPair | output | 2*NUM_PORTS | Horizontal quadrature pair per port, quadrature bit high |
| vertPair | output | 2*NUM_PORTS | Vertical quadrature pair per port, quadrature bit high |
| statusByte | output | MISC_BITS | Latched miscellaneous control bits |
| frameDone | output | 1 | One-cycle pulse after a frame is committed |

## Verification
The bench builds the block with DIV_HALF = 3, NUM_PORTS = 2 and MISC_BITS = 8. A divider that is odd and greater than one exposes off-by-one errors in the phase counter, and each phase width is short enough to count cycle by cycle. A frame lasts 102 cycles, so the bench can run a walking-one pattern through every stream position. This checks the bit-to-port mapping and the status-byte order one bit at a time, and it still leaves time to watch the outputs hold steady across a whole frame while the next value shifts in.

// File: rtl/ctrl_rx_pkg.sv
package ctrl_rx_pkg;

  // Strobes from the control sequencer to the capture datapath.
  typedef struct packed {
    logic sample;   // take serIn on this edge (serial clock rising)
    logic lastBit;  // this sample completes the frame
  } rxStrobe_t;

endpackage

// File: rtl/ctrl_rx_ctrl.sv
module ctrl_rx_ctrl
  import ctrl_rx_pkg::*;
#(
  parameter int DIV_HALF   = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic      clk,
  input  logic      rst,
  output logic      loadOut,
  output logic      sclkOut,
  output rxStrobe_t strobe
);

  // Half-periods: two for the load strobe, two per data bit.
  localparam int HALVES = 2 * (FRAME_BITS + 1);
  localparam int HALF_W = $clog2(HALVES);
  localparam int DIV_W  = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DIV_W-1:0]  divCnt, divNext;
  logic [HALF_W-1:0] halfIdx, halfNext;
  logic              atEnd;
  logic              loadNext, sclkNext;

  always_comb begin
    atEnd = (divCnt == DIV_W'(DIV_HALF - 1));
    if (atEnd) begin
      divNext  = '0;
      halfNext = (halfIdx == HALF_W'(HALVES - 1)) ? '0 : halfIdx + 1'b1;
    end else begin
      divNext  = divCnt + 1'b1;
      halfNext = halfIdx;
    end
    loadNext = (halfNext < HALF_W'(2));
    sclkNext = (halfNext >= HALF_W'(2)) && halfNext[0];
  end

  // A sample happens when a low data half-period ends.
  always_comb begin
    strobe.sample  = atEnd && (halfIdx >= HALF_W'(2)) && !halfIdx[0];
    strobe.lastBit = (halfIdx == HALF_W'(HALVES - 2));
  end

  // Reset parks the sequencer at the end of a frame, so the
  // first edge after reset opens a full-width load strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= DIV_W'(DIV_HALF - 1);
      halfIdx <= HALF_W'(HALVES - 1);
      loadOut <= 1'b0;
      sclkOut <= 1'b0;
    end else begin
      divCnt  <= divNext;
      halfIdx <= halfNext;
      loadOut <= loadNext;
      sclkOut <= sclkNext;
    end
  end

  // ---------------- assertions ----------------
  logic [31:0] loadRun;
  always_ff @(posedge clk) begin
    if (rst)          loadRun <= '0;
    else if (loadOut) loadRun <= loadRun + 1'b1;
    else              loadRun <= '0;
  end

  a_r2_load_width: assert property (@(posedge clk) disable iff (rst)
    $fell(loadOut) |-> (loadRun == 32'(2 * DIV_HALF)));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(loadOut && sclkOut));

  a_r4_sample_edge: assert property (@(posedge clk) disable iff (rst)
    strobe.sample |=> $rose(sclkOut));

  a_r3_rise_sampled: assert property (@(posedge clk) disable iff (rst)
    $rose(sclkOut) |-> $past(strobe.sample));

endmodule

// File: rtl/ctrl_rx_dp.sv
module ctrl_rx_dp
  import ctrl_rx_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int MISC_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   serIn,
  input  rxStrobe_t              strobe,
  output logic [2*NUM_PORTS-1:0] horizPair,
  output logic [2*NUM_PORTS-1:0] vertPair,
  output logic [MISC_BITS-1:0]   statusByte,
  output logic                   frameDone
);

  localparam int QUAD_BITS  = 4 * NUM_PORTS;
  localparam int FRAME_BITS = QUAD_BITS + MISC_BITS;

  logic [FRAME_BITS-1:0] shiftReg, nextShift, frameReg;
  logic                  commit;

  // Bits arrive first-to-last; after a full frame, bit 0 sits at position 0.
  assign nextShift = {serIn, shiftReg[FRAME_BITS-1:1]};
  assign commit    = strobe.sample && strobe.lastBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      frameReg  <= '0;
      frameDone <= 1'b0;
    end else begin
      if (strobe.sample) shiftReg <= nextShift;
      if (commit)        frameReg <= nextShift;
      frameDone <= commit;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign horizPair[2*p +: 2] = frameReg[4*p +: 2];
    assign vertPair[2*p +: 2]  = frameReg[4*p+2 +: 2];
  end

  assign statusByte = frameReg[FRAME_BITS-1:QUAD_BITS];

  // ---------------- assertions ----------------
  a_r7_atomic: assert property (@(posedge clk) disable iff (rst)
    !frameDone |-> ($stable(statusByte) && $stable(horizPair) && $stable(vertPair)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone);

  a_r7_done_cause: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> $past(strobe.sample && strobe.lastBit));

endmodule

// File: rtl/ctrl_serial_rx.sv
module ctrl_serial_rx
  import ctrl_rx_pkg::*;
#(
  parameter int DIV_HALF  = 4,
  parameter int NUM_PORTS = 2,
  parameter int MISC_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   serIn,
  output logic                   loadOut,
  output logic                   sclkOut,
  output logic [2*NUM_PORTS-1:0] horizPair,
  output logic [2*NUM_PORTS-1:0] vertPair,
  output logic [MISC_BITS-1:0]   statusByte,
  output logic                   frameDone
);

  localparam int FRAME_BITS = 4 * NUM_PORTS + MISC_BITS;

  rxStrobe_t strobe;

  ctrl_rx_ctrl #(
    .DIV_HALF  (DIV_HALF),
    .FRAME_BITS(FRAME_BITS)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .loadOut(loadOut),
    .sclkOut(sclkOut),
    .strobe (strobe)
  );

  ctrl_rx_dp #(
    .NUM_PORTS(NUM_PORTS),
    .MISC_BITS(MISC_BITS)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .serIn     (serIn),
    .strobe    (strobe),
    .horizPair (horizPair),
    .vertPair  (vertPair),
    .statusByte(statusByte),
    .frameDone (frameDone)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!loadOut && !sclkOut && !frameDone && statusByte == '0));

endmodule

// File: tb/ctrl_serial_rx_tb_top.sv
module ctrl_serial_rx_tb_top;

  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serIn;
  logic       loadOut, sclkOut, frameDone;
  logic [3:0] horizPair, vertPair;
  logic [7:0] statusByte;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ctrl_serial_rx #(.DIV_HALF(D), .NUM_PORTS(2), .MISC_BITS(8)) dut_i (
    .clk(clk), .rst(rst), .serIn(serIn),
    .loadOut(loadOut), .sclkOut(sclkOut),
    .horizPair(horizPair), .vertPair(vertPair),
    .statusByte(statusByte), .frameDone(frameDone)
  );

  // External parallel-in serial-out converter: loads while the strobe
  // is high, advances on each falling edge of the serial clock.
  logic [15:0] par = 16'h0000;
  logic [15:0] sh  = 16'h0000;
  logic        sclkPrev = 1'b0;
  assign serIn = sh[0];

  always @(negedge clk) begin
    if (loadOut)                 sh <= par;
    else if (sclkPrev && !sclkOut) sh <= {1'b0, sh[15:1]};
    sclkPrev <= sclkOut;
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [3:0] expHoriz(input logic [15:0] v);
    return {v[5], v[4], v[1], v[0]};
  endfunction
  function automatic logic [3:0] expVert(input logic [15:0] v);
    return {v[7], v[6], v[3], v[2]};
  endfunction

  task automatic waitDone();
    @(negedge clk);
    while (!frameDone) @(negedge clk);
  endtask

  // R1 and the start of R2
  task automatic testReset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk({loadOut, sclkOut, frameDone, horizPair, vertPair, statusByte} == '0,
        "R1 reset outputs", {loadOut, sclkOut, frameDone, statusByte}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(loadOut == 1'b1, "R2 load after reset", loadOut, 1);
    chk(horizPair == 0 && vertPair == 0 && statusByte == 0, "R1 quiet after reset",
        {horizPair, vertPair, statusByte}, 0);
  endtask

  // R2, R3, R8: called at the negedge where loadOut first reads high
  task automatic testTiming();
    int n = 0;
    int badLow = 0;
    int badHigh = 0;
    int overlap = 0;
    while (loadOut && n < 1000) begin
      if (sclkOut) overlap++;
      n++;
      @(negedge clk);
    end
    chk(n == 2 * D, "R2 load width", n, 2 * D);
    chk(overlap == 0, "R2 no overlap", overlap, 0);
    for (int b = 0; b < 16; b++) begin
      int lo = 0;
      int hi = 0;
      while (!sclkOut && !loadOut && lo < 1000) begin lo++; @(negedge clk); end
      while (sclkOut && hi < 1000) begin hi++; @(negedge clk); end
      if (lo != D) badLow++;
      if (hi != D) badHigh++;
    end
    chk(badLow == 0, "R3 low phase widths", badLow, 0);
    chk(badHigh == 0, "R3 high phase widths", badHigh, 0);
    chk(loadOut == 1'b1, "R8 reload right after last bit", loadOut, 1);
  endtask

  // R4, R5, R6, R7: one frame carrying v
  task automatic sendFrame(input logic [15:0] v, input string tag);
    waitDone();
    par = v;
    waitDone();
    chk(horizPair == expHoriz(v), {tag, " horizontal pairs"}, horizPair, expHoriz(v));
    chk(vertPair == expVert(v), {tag, " vertical pairs"}, vertPair, expVert(v));
    chk(statusByte == v[15:8], {tag, " status byte"}, statusByte, v[15:8]);
    @(negedge clk);
    chk(frameDone == 1'b0, "R7 done is one cycle", frameDone, 0);
  endtask

  // R7: outputs hold the old frame while the new one shifts in
  task automatic testAtomic(input logic [15:0] oldV, input logic [15:0] newV);
    int changed = 0;
    int cycles = 0;
    waitDone();
    par = oldV;
    waitDone();
    par = newV;
    @(negedge clk);
    while (!frameDone && cycles < 1000) begin
      if (statusByte != oldV[15:8] || horizPair != expHoriz(oldV) ||
          vertPair != expVert(oldV)) changed++;
      cycles++;
      @(negedge clk);
    end
    chk(changed == 0, "R7 outputs hold mid frame", changed, 0);
    chk(cycles == 2 * D * 17 - 1, "R8 frame period", cycles, 2 * D * 17 - 1);
    chk(statusByte == newV[15:8], "R7 new frame committed", statusByte, newV[15:8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    testReset();
    testTiming();
    sendFrame(16'hA5C3, "R4 R5 R6 mixed");
    sendFrame(16'hFFFF, "R5 R6 all ones");
    sendFrame(16'h0000, "R5 R6 all zeros");
    sendFrame(16'h3C5A, "R4 R6 alternate");
    for (int i = 0; i < 16; i++) begin
      sendFrame(16'(1) << i, "R4 R5 R6 walking one");
    end
    testAtomic(16'h12F0, 16'hED0F);
    finishRun();
  end

endmodule